// File: doc/BRIEF.md
# Multi-Mode Radix-2 Butterfly Engine

This block computes one radix-2 FFT butterfly per clock on signed fixed-point complex data. Each operand set holds two complex inputs A and B, one complex twiddle W and three controls. A two-bit mode selects the butterfly form. In the time-decimation form the twiddle multiply comes before the sum and difference. In the frequency-decimation form it comes after them. Either form can also turn the twiddle by a quarter turn. A quarter-turn lets one table of twiddles cover twice the angle range. An inverse control conjugates the twiddle, so the forward table also serves the inverse transform. A scale control halves both results, which gives block scaling per stage.

Operand sets enter through a valid/ready port and results leave through a second valid/ready port. The pipeline has a fixed depth and moves as one unit. While `out_ready` is high it accepts one set per cycle and advances. While `out_ready` is low, every stage holds and `in_ready` is low, so the upstream source must keep its set on the inputs. A producer therefore sees exactly the consumer's back-pressure. Nothing is lost or repeated. The controls are captured with their operands, so consecutive sets may use different modes.

Top module: `fft_bfly_engine`

## Requirements
- R1: Mode code 2'b00 (bit 1 = frequency form, bit 0 = quarter turn) computes P = sat16(cmul(B, W')), X = A + P, Y = A − P. W' is the prepared twiddle.
- R2: Mode code 2'b10 computes X = A + B and Y = cmul(A − B, W'). Y is not saturated before the output stage.
- R3: When mode bit 0 is set, the twiddle is multiplied by −j before use: re' = im, im' = −re. This uses no second multiply.
- R4: When `in_inverse` is high, the imaginary part of the twiddle is negated after any rotation. The quarter turn then becomes +j.
- R5: Complex products are formed as re = rnd(ar·wr − ai·wi) and im = rnd(ar·wi + ai·wr), where rnd(p) = (p + 2^14) >>> 15 and W is Q1.15. Every negation and every output saturates to the 16-bit range [−32768, 32767].
- R6: When `in_scale` is high, each raw output v becomes (v + 1) >>> 1 before the final saturation.
- R7: With `out_ready` held high, a set accepted at one rising edge is delivered at the 16th rising edge after it. A new set is accepted on every cycle.
- R8: Mode, inverse and scale are captured with their operands. Sets that follow each other with different controls are each computed with their own controls.
- R9: While `out_ready` is low, `in_ready` is low and the whole pipeline holds. `out_valid` and the output data stay unchanged, and results leave in acceptance order with none dropped or repeated.
- R10: A synchronous active-high `rst` empties the pipeline. `out_valid` is low after it, and sets in flight at reset never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Engine takes the set at this edge |
| in_mode | input | 2 | Bit 1 frequency form, bit 0 quarter turn |
| in_inverse | input | 1 | Conjugate the twiddle |
| in_scale | input | 1 | Halve both results |
| in_a_re | input | 16 | A real part |
| in_a_im | input | 16 | A imaginary part |
| in_b_re | input | 16 | B real part |
| in_b_im | input | 16 | B imaginary part |
| in_w_re | input | 16 | Twiddle real part, Q1.15 |
| in_w_im | input | 16 | Twiddle imaginary part, Q1.15 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_x_re | output | 16 | X real part |
| out_x_im | output | 16 | X imaginary part |
| out_y_re | output | 16 | Y real part |
| out_y_im | output | 16 | Y imaginary part |

## Verification
The bench drives all sixteen control combinations. Operands mix −32768, 32767, ±1 and other edge values with pseudo-random ones. The controls change on every cycle, so a pipeline that let a control slip one stage against its data would give wrong values in the next set.

Full-scale values test the saturation and rounding points. They expose a missing clamp, which would wrap to the opposite sign. They also expose a rounding offset applied at the wrong place, which would leave a one-LSB error. The −32768 twiddle part tests rotation and conjugation, because a plain negation of that value wraps back to itself. A random back-pressure phase exposes a pipeline that keeps moving under stall, which would drop or repeat results or change data held on the outputs. A mid-flight reset exposes stale valid bits, which would let discarded sets reappear.

// File: rtl/fft_bfly_pkg.sv
package fft_bfly_pkg;

  typedef enum logic [1:0] {
    MODE_DIT     = 2'b00,
    MODE_DIT_ROT = 2'b01,
    MODE_DIF     = 2'b10,
    MODE_DIF_ROT = 2'b11
  } bfly_mode_e;

  typedef struct packed {
    logic dif;
    logic rot;
    logic inv;
    logic scl;
  } bfly_ctrl_t;

  function automatic bfly_ctrl_t decode_ctrl(input logic [1:0] mode,
                                             input logic inv,
                                             input logic scl);
    bfly_ctrl_t c;
    c.inv = inv;
    c.scl = scl;
    case (bfly_mode_e'(mode))
      MODE_DIT:     begin c.dif = 1'b0; c.rot = 1'b0; end
      MODE_DIT_ROT: begin c.dif = 1'b0; c.rot = 1'b1; end
      MODE_DIF:     begin c.dif = 1'b1; c.rot = 1'b0; end
      default:      begin c.dif = 1'b1; c.rot = 1'b1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fft_twiddle_prep.sv
module fft_twiddle_prep #(
  parameter int TW = 16
) (
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  input  logic                 rot,
  input  logic                 inv,
  output logic signed [TW-1:0] q_re,
  output logic signed [TW-1:0] q_im
);

  localparam logic signed [TW-1:0] MOST_NEG = {1'b1, {(TW-1){1'b0}}};
  localparam logic signed [TW-1:0] MOST_POS = {1'b0, {(TW-1){1'b1}}};

  function automatic logic signed [TW-1:0] neg_sat(input logic signed [TW-1:0] v);
    return (v == MOST_NEG) ? MOST_POS : -v;
  endfunction

  logic signed [TW-1:0] r_re, r_im;

  // quarter turn by -j: swap parts, negate the new imaginary part
  always_comb begin
    if (rot) begin
      r_re = w_im;
      r_im = neg_sat(w_re);
    end else begin
      r_re = w_re;
      r_im = w_im;
    end
    q_re = r_re;
    q_im = inv ? neg_sat(r_im) : r_im;
  end

endmodule

// File: rtl/fft_cmul_rnd.sv
module fft_cmul_rnd #(
  parameter int OW = 17,
  parameter int TW = 16
) (
  input  logic                        clk,
  input  logic                        en,
  input  logic signed [OW-1:0]        a_re,
  input  logic signed [OW-1:0]        a_im,
  input  logic signed [TW-1:0]        w_re,
  input  logic signed [TW-1:0]        w_im,
  output logic signed [OW+TW+1-(TW-1)-1:0] p_re,
  output logic signed [OW+TW+1-(TW-1)-1:0] p_im
);

  localparam int FRAC = TW - 1;
  localparam int MW   = OW + TW;
  localparam int PW   = MW + 1;
  localparam int RW   = PW - FRAC;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

  logic signed [MW-1:0] pp_rr, pp_ii, pp_ri, pp_ir;
  logic signed [PW-1:0] s_re, s_im;

  // stage one: four partial products
  always_ff @(posedge clk) begin
    if (en) begin
      pp_rr <= a_re * w_re;
      pp_ii <= a_im * w_im;
      pp_ri <= a_re * w_im;
      pp_ir <= a_im * w_re;
    end
  end

  assign s_re = PW'(pp_rr) - PW'(pp_ii) + HALF;
  assign s_im = PW'(pp_ri) + PW'(pp_ir) + HALF;

  // stage two: combine, round to nearest, drop fraction bits
  always_ff @(posedge clk) begin
    if (en) begin
      p_re <= s_re[PW-1:FRAC];
      p_im <= s_im[PW-1:FRAC];
    end
  end

  initial begin
    if (RW != OW + 2) $error("fft_cmul_rnd: width derivation mismatch");
  end

endmodule

// File: rtl/fft_delay_line.sv
module fft_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] st [DEPTH];
      always_ff @(posedge clk) begin
        if (en) begin
          st[0] <= din;
          for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
        end
      end
      assign dout = st[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/fft_bfly_engine.sv
module fft_bfly_engine
  import fft_bfly_pkg::*;
#(
  parameter int DW  = 16,
  parameter int TW  = 16,
  parameter int LAT = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic          in_inverse,
  input  logic          in_scale,
  input  logic [DW-1:0] in_a_re,
  input  logic [DW-1:0] in_a_im,
  input  logic [DW-1:0] in_b_re,
  input  logic [DW-1:0] in_b_im,
  input  logic [TW-1:0] in_w_re,
  input  logic [TW-1:0] in_w_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_x_re,
  output logic [DW-1:0] out_x_im,
  output logic [DW-1:0] out_y_re,
  output logic [DW-1:0] out_y_im
);

  localparam int OW   = DW + 1;
  localparam int FRAC = TW - 1;
  localparam int PW   = OW + TW + 1;
  localparam int RW   = PW - FRAC;
  localparam int SW   = RW + 1;
  localparam int CST  = 5;
  localparam int DLY  = LAT - CST;
  localparam int PASSW = 2 * OW + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((2 ** (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(2 ** (DW - 1));

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [SW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic logic signed [SW-1:0] halve(input logic signed [SW-1:0] v,
                                                 input logic en_h);
    return en_h ? ((v + SW'(1)) >>> 1) : v;
  endfunction

  // the whole pipeline moves only when the consumer can take a result
  logic adv;
  assign adv      = out_ready;
  assign in_ready = adv;

  // valid chain, the only reset state
  logic [LAT-1:0] vld;
  always_ff @(posedge clk) begin
    if (rst)      vld <= '0;
    else if (adv) vld <= {vld[LAT-2:0], in_valid};
  end
  assign out_valid = vld[LAT-1];

  // stage 1: capture
  logic signed [DW-1:0] s1_a_re, s1_a_im, s1_b_re, s1_b_im;
  logic signed [TW-1:0] s1_w_re, s1_w_im;
  bfly_ctrl_t           s1_ctl;
  always_ff @(posedge clk) begin
    if (adv) begin
      s1_a_re <= in_a_re;  s1_a_im <= in_a_im;
      s1_b_re <= in_b_re;  s1_b_im <= in_b_im;
      s1_w_re <= in_w_re;  s1_w_im <= in_w_im;
      s1_ctl  <= decode_ctrl(in_mode, in_inverse, in_scale);
    end
  end

  // stage 2: twiddle prep and operand steering
  logic signed [TW-1:0] wq_re, wq_im;
  fft_twiddle_prep #(.TW(TW)) u_prep (
    .w_re(s1_w_re), .w_im(s1_w_im), .rot(s1_ctl.rot), .inv(s1_ctl.inv),
    .q_re(wq_re), .q_im(wq_im)
  );

  logic signed [OW-1:0] ext_a_re, ext_a_im, ext_b_re, ext_b_im;
  assign ext_a_re = OW'(s1_a_re);
  assign ext_a_im = OW'(s1_a_im);
  assign ext_b_re = OW'(s1_b_re);
  assign ext_b_im = OW'(s1_b_im);

  logic signed [TW-1:0] s2_w_re, s2_w_im;
  logic signed [OW-1:0] s2_m_re, s2_m_im, s2_p_re, s2_p_im;
  logic                 s2_dif, s2_scl;
  always_ff @(posedge clk) begin
    if (adv) begin
      s2_w_re <= wq_re;
      s2_w_im <= wq_im;
      s2_dif  <= s1_ctl.dif;
      s2_scl  <= s1_ctl.scl;
      if (s1_ctl.dif) begin
        s2_m_re <= ext_a_re - ext_b_re;
        s2_m_im <= ext_a_im - ext_b_im;
        s2_p_re <= ext_a_re + ext_b_re;
        s2_p_im <= ext_a_im + ext_b_im;
      end else begin
        s2_m_re <= ext_b_re;
        s2_m_im <= ext_b_im;
        s2_p_re <= ext_a_re;
        s2_p_im <= ext_a_im;
      end
    end
  end

  // stages 3-4: complex multiply, with side terms delayed alongside
  logic signed [RW-1:0] pr_re, pr_im;
  fft_cmul_rnd #(.OW(OW), .TW(TW)) u_cmul (
    .clk(clk), .en(adv),
    .a_re(s2_m_re), .a_im(s2_m_im), .w_re(s2_w_re), .w_im(s2_w_im),
    .p_re(pr_re), .p_im(pr_im)
  );

  logic [PASSW-1:0] side_d;
  fft_delay_line #(.W(PASSW), .DEPTH(2)) u_side (
    .clk(clk), .en(adv),
    .din({s2_p_re, s2_p_im, s2_dif, s2_scl}),
    .dout(side_d)
  );

  logic signed [OW-1:0] s4_p_re, s4_p_im;
  logic                 s4_dif, s4_scl;
  assign {s4_p_re, s4_p_im, s4_dif, s4_scl} = side_d;

  // stage 5: sum/difference or pass-through, scale, saturate
  logic signed [DW-1:0] pc_re, pc_im;
  logic signed [SW-1:0] rx_re, rx_im, ry_re, ry_im;
  always_comb begin
    pc_re = sat_dw(SW'(pr_re));
    pc_im = sat_dw(SW'(pr_im));
    if (s4_dif) begin
      rx_re = SW'(s4_p_re);
      rx_im = SW'(s4_p_im);
      ry_re = SW'(pr_re);
      ry_im = SW'(pr_im);
    end else begin
      rx_re = SW'(s4_p_re) + SW'(pc_re);
      rx_im = SW'(s4_p_im) + SW'(pc_im);
      ry_re = SW'(s4_p_re) - SW'(pc_re);
      ry_im = SW'(s4_p_im) - SW'(pc_im);
    end
  end

  logic [4*DW-1:0] s5_res;
  always_ff @(posedge clk) begin
    if (adv) begin
      s5_res <= {sat_dw(halve(rx_re, s4_scl)), sat_dw(halve(rx_im, s4_scl)),
                 sat_dw(halve(ry_re, s4_scl)), sat_dw(halve(ry_im, s4_scl))};
    end
  end

  // padding to the fixed latency
  logic [4*DW-1:0] res_d;
  fft_delay_line #(.W(4*DW), .DEPTH(DLY)) u_pad (
    .clk(clk), .en(adv), .din(s5_res), .dout(res_d)
  );

  assign {out_x_re, out_x_im, out_y_re, out_y_im} = res_d;

  initial begin
    if (LAT < CST + 1) $error("fft_bfly_engine: LAT too small");
  end

endmodule

// File: rtl/fft_bfly_checker.sv
module fft_bfly_checker #(
  parameter int DW  = 16,
  parameter int LAT = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [4*DW-1:0] out_data
);

  localparam int CW = $clog2(LAT + 1) + 2;

  logic [CW-1:0] inflight;
  logic          acc, del;
  assign acc = in_valid && in_ready;
  assign del = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(acc) - CW'(del);
  end

  // R10: reset leaves no valid result behind
  a_r10_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  // R9: a stalled pipeline keeps its output valid bit
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> $stable(out_valid));

  // R9: a held result keeps its data
  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R7: never more sets in flight than pipeline stages
  a_r7_occupancy: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT));

  // R9: no result appears that was not accepted earlier
  a_r9_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

endmodule

bind fft_bfly_engine fft_bfly_checker #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_data({out_x_re, out_x_im, out_y_re, out_y_im})
);

// File: tb/fft_bfly_engine_test.sv
`timescale 1ns/1ps
module fft_bfly_engine_test;

  localparam int LAT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'b00;
  logic        in_inverse = 1'b0;
  logic        in_scale = 1'b0;
  logic [15:0] in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
  logic [15:0] in_w_re = '0, in_w_im = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_x_re, out_x_im, out_y_re, out_y_im;

  always #2.5 clk = ~clk;

  fft_bfly_engine uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_inverse(in_inverse), .in_scale(in_scale),
    .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
    .in_w_re(in_w_re), .in_w_im(in_w_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x_re(out_x_re), .out_x_im(out_x_im), .out_y_re(out_y_re), .out_y_im(out_y_im)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit fire_in = 0;
  bit lat_chk = 0;
  bit bp_en   = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  logic [63:0] exp_q[$];
  int          acc_q[$];
  string       tag_q[$];

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint nsat(input longint v);
    return (v == -32768) ? 32767 : -v;
  endfunction

  function automatic longint rnd15(input longint p);
    return (p + 16384) >>> 15;
  endfunction

  function automatic longint fin(input longint v, input bit s);
    return sat16(s ? ((v + 1) >>> 1) : v);
  endfunction

  function automatic logic [63:0] model(input logic [1:0] m, input bit inv, input bit s,
      input longint ar, input longint ai, input longint br, input longint bi,
      input longint wr0, input longint wi0);
    longint wr, wi, t, pr, pi, xr, xi, yr, yi, dr, di;
    wr = wr0; wi = wi0;
    if (m[0]) begin t = wr; wr = wi; wi = nsat(t); end       // R3
    if (inv) wi = nsat(wi);                                  // R4
    if (!m[1]) begin                                         // R1
      pr = sat16(rnd15(br * wr - bi * wi));
      pi = sat16(rnd15(br * wi + bi * wr));
      xr = ar + pr; xi = ai + pi; yr = ar - pr; yi = ai - pi;
    end else begin                                           // R2
      xr = ar + br; xi = ai + bi;
      dr = ar - br; di = ai - bi;
      yr = rnd15(dr * wr - di * wi);
      yi = rnd15(dr * wi + di * wr);
    end
    return {16'(fin(xr, s)), 16'(fin(xi, s)), 16'(fin(yr, s)), 16'(fin(yi, s))};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: samples half a nanosecond before each rising edge
  logic [63:0] prev_data;
  bit          prev_stall = 0;
  always begin
    @(negedge clk);
    #2;
    cyc++;
    if (rst) begin
      exp_q.delete(); acc_q.delete(); tag_q.delete();
      prev_stall = 0;
      fire_in = 0;
    end else begin
      logic [63:0] act;
      act = {out_x_re, out_x_im, out_y_re, out_y_im};
      fire_in = in_valid && in_ready;
      if (!out_ready)
        check(in_ready == 1'b0, "R9 in_ready low under stall", 64'(in_ready), 64'd0);
      if (prev_stall)
        check(out_valid && act == prev_data, "R9 held result", act, prev_data);
      if (fire_in) begin
        string tg;
        tg = in_mode[1] ? "R2" : "R1";
        if (in_mode[0]) tg = {tg, " R3"};
        if (in_inverse) tg = {tg, " R4"};
        if (in_scale)   tg = {tg, " R6"};
        tg = {tg, " R5 R8"};
        exp_q.push_back(model(in_mode, in_inverse, in_scale,
          longint'($signed(in_a_re)), longint'($signed(in_a_im)),
          longint'($signed(in_b_re)), longint'($signed(in_b_im)),
          longint'($signed(in_w_re)), longint'($signed(in_w_im))));
        acc_q.push_back(cyc);
        tag_q.push_back(tg);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", act, 64'd0);
        end else begin
          logic [63:0] e;
          int a;
          string tg;
          e = exp_q.pop_front(); a = acc_q.pop_front(); tg = tag_q.pop_front();
          check(act == e, tg, act, e);
          if (lat_chk)
            check(cyc - a == LAT, "R7 latency", 64'(cyc - a), 64'(LAT));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = act;
    end
  end

  // back-pressure source
  always @(negedge clk) begin
    if (bp_en) begin
      seed = xs(seed);
      out_ready <= seed[3] | seed[7];
    end else begin
      out_ready <= 1'b1;
    end
  end

  task automatic send(input logic [1:0] m, input bit inv, input bit s,
                      input logic [15:0] ar, input logic [15:0] ai,
                      input logic [15:0] br, input logic [15:0] bi,
                      input logic [15:0] wr, input logic [15:0] wi);
    in_valid = 1'b1; in_mode = m; in_inverse = inv; in_scale = s;
    in_a_re = ar; in_a_im = ai; in_b_re = br; in_b_im = bi;
    in_w_re = wr; in_w_im = wi;
    do @(posedge clk); while (!fire_in);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] corner(input int k);
    case (k % 8)
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return 16'h0000;
      3: return 16'h0001;
      4: return 16'hffff;
      5: return 16'h4000;
      6: return 16'hc000;
      default: return 16'h3039;
    endcase
  endfunction

  task automatic send_pat(input int ctl, input int n);
    logic [15:0] v[6];
    for (int k = 0; k < 6; k++) begin
      seed = xs(seed);
      v[k] = (n % 3 == 0) ? corner(n / 3 + k * 3 + ctl) : seed[15:0];
    end
    send(ctl[1:0], ctl[2], ctl[3], v[0], v[1], v[2], v[3], v[4], v[5]);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9 in_ready idle", 64'(in_ready), 64'd1);

    // R1 R2 R3 R4 R6 R8: every control set, corners and random, back to back
    @(negedge clk);
    lat_chk = 1;
    for (int n = 0; n < 40; n++)
      for (int ctl = 0; ctl < 16; ctl++) send_pat(ctl, n);
    // R5: full-scale saturation cases
    send(2'b00, 0, 0, 16'h7fff, 16'h7fff, 16'h7fff, 16'h7fff, 16'h7fff, 16'h0000);
    send(2'b10, 0, 0, 16'h7fff, 16'h8000, 16'h8000, 16'h7fff, 16'h8000, 16'h8000);
    send(2'b11, 1, 0, 16'h8000, 16'h8000, 16'h7fff, 16'h7fff, 16'h8000, 16'h8000);
    send(2'b01, 1, 1, 16'h8000, 16'h7fff, 16'h8000, 16'h8000, 16'h8000, 16'h7fff);
    repeat (LAT + 4) @(negedge clk);
    lat_chk = 0;

    // R9: random back-pressure with gaps on the input side
    bp_en = 1;
    for (int n = 0; n < 300; n++) begin
      seed = xs(seed);
      if (seed[1:0] == 2'b00) @(negedge clk);
      send_pat(int'(seed[7:4]), n);
    end
    repeat (120) @(negedge clk);
    bp_en = 0;
    repeat (LAT + 4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results delivered", 64'(exp_q.size()), 64'd0);

    // R10: reset with sets in flight
    for (int n = 0; n < 6; n++) send_pat(n, n);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < LAT + 4; n++) begin
      @(negedge clk); #1;
      check(out_valid == 1'b0, "R10 flushed set absent", 64'(out_valid), 64'd0);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule